// File: doc/BRIEF.md
# Tunable-Precision Significand Rounder

This unit sits behind the partial-product tree of a floating-point multiplier whose precision can change on every operation. It receives the full double-width product of two significands, hidden bits included, so the product lies between 1.0 and just under 4.0. With it comes a precision value `m` that says how many significand bits the result keeps. The unit normalizes the product and rounds it to `m` bits using round-to-nearest, ties-to-even. It returns the stored fraction, which leaves out the hidden bit, and an exponent adjustment that the exponent path adds to its sum. A flush input forces the result to zero. The flush comes from the exponent path when the result underflows or overflows.

The rounding is speculative. The unit forms one half-ulp increment for a leading one at bit 47 and another for a leading one at bit 46. It then picks the candidate that matches the actual leading one. When the discarded bits are exactly one half and the kept LSB is 0, it picks the unincremented product instead. A decoder driven by `m` places the increment, builds the sticky-bit window and builds the mask that clears the fraction bits below the precision.

Operations enter on a valid/ready stream and leave on another, with one register stage in between. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high, and its result is valid from the next edge. `in_ready` is high when the output register is empty or is being drained that cycle, so back-pressure from `o_ready` stalls the input with no extra buffering. While `o_valid` is high and `o_ready` is low, the output holds its value.

Top module: `sig_round_unit`

## Requirements
- R1: For a product with bit 47 clear (leading one at bit 46), the result is the product rounded to nearest at `m` bits below and including bit 46. `o_adj` is 0 unless rounding carries into bit 47.
- R2: For a product with bit 47 set, rounding is at `m` bits below and including bit 47, and `o_adj` is 1 unless rounding carries into bit 48.
- R3: When the discarded part equals exactly half an ulp, the result keeps an even LSB. It rounds down when the kept LSB is 0 and up when it is 1.
- R4: A carry out of the rounding gives `o_frac` = 0. The carry raises `o_adj` from 0 to 1 for a bit-46 leading one, and from 1 to 2 for a bit-47 leading one. `o_adj` never equals 3.
- R5: A precision value of 25 to 31 truncates the normalized product to 24 bits (round toward zero).
- R6: A precision value of 0 to 3 behaves exactly as 4.
- R7: `o_frac` bit 22 is the first bit after the hidden one. The lowest 24−m fraction bits are always zero.
- R8: With `in_flush` high, the accepted result has `o_frac` = 0 and `o_adj` = 0 regardless of the product.
- R9: An operation is accepted when `in_valid` and `in_ready` are both high, and its result is valid at the next edge. `in_ready` is low exactly while a result waits with `o_ready` low. With `o_ready` held high, one operation passes per cycle.
- R10: While `o_valid` is high and `o_ready` is low, `o_valid`, `o_frac` and `o_adj` hold.
- R11: After reset, `o_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input operation present |
| in_ready | output | 1 | Unit can accept an operation |
| in_prod | input | 48 | Significand product, in [2^46, 2^48) |
| in_prec | input | 5 | Kept significand bits m (4..24; below 4 clamps, above 24 truncates) |
| in_flush | input | 1 | Force a zero result |
| o_valid | output | 1 | Result present |
| o_ready | input | 1 | Consumer accepts the result |
| o_frac | output | 23 | Rounded fraction without hidden bit |
| o_adj | output | 2 | Exponent increment: 0, 1 or 2 |

## Verification
The bench sweeps every precision code from 0 to 31 and compares results against an arithmetic nearest-even model. For each code it builds exact ties at both leading-one positions: selecting the incremented sum on a tie would leave an odd LSB. The all-ones products must carry into a new leading one. A unit that lets the rounded candidate at the upper position choose the normalization would round the top-m-ones, R-clear, bit-46 product up to 2.0 instead of leaving it alone. Back-pressure stalls and back-to-back streaming expose a register stage that drops or overwrites a held result.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
  localparam int SIG_W    = 24;
  localparam int PREC_W   = 5;
  localparam int MIN_PREC = 4;

  typedef enum logic [1:0] {
    ADJ_NONE = 2'd0,
    ADJ_ONE  = 2'd1,
    ADJ_TWO  = 2'd2
  } exp_adj_e;
endpackage

// File: rtl/tfr_decode.sv
module tfr_decode #(
  parameter int SIG_W    = 24,
  parameter int PREC_W   = 5,
  parameter int MIN_PREC = 4
) (
  input  logic [PREC_W-1:0] prec,
  output logic              trunc,
  output logic [2*SIG_W:0]  rnd_lo,
  output logic [2*SIG_W:0]  below_lo,
  output logic [SIG_W-1:0]  keep
);
  localparam int SUM_W = 2*SIG_W + 1;

  logic [PREC_W-1:0] meff;
  int                lo_pos;

  always_comb begin
    trunc = int'(prec) > SIG_W;
    if (trunc)                     meff = PREC_W'(SIG_W);
    else if (int'(prec) < MIN_PREC) meff = PREC_W'(MIN_PREC);
    else                           meff = prec;
    lo_pos = 2*SIG_W - 2 - int'(meff);
  end

  // one-hot half-ulp for a bit-46 leading one, thermometer of bits below it
  for (genvar j = 0; j < SUM_W; j++) begin : g_word
    assign rnd_lo[j]   = !trunc && (j == lo_pos);
    assign below_lo[j] = !trunc && (j < lo_pos);
  end

  // top meff bits of the normalized significand survive
  for (genvar i = 0; i < SIG_W; i++) begin : g_keep
    assign keep[SIG_W-1-i] = (i < int'(meff));
  end
endmodule

// File: rtl/tfr_tie.sv
module tfr_tie #(
  parameter int SUM_W = 49
) (
  input  logic [SUM_W-1:0] prod,
  input  logic [SUM_W-1:0] l_pos,
  input  logic [SUM_W-1:0] r_pos,
  input  logic [SUM_W-1:0] below,
  output logic             tie
);
  logic l_bit, r_bit, sticky;

  always_comb begin
    l_bit  = |(prod & l_pos);
    r_bit  = |(prod & r_pos);
    sticky = |(prod & below);
    tie    = !l_bit && r_bit && !sticky;
  end
endmodule

// File: rtl/tfr_pick.sv
module tfr_pick
  import tfr_pkg::*;
#(
  parameter int SIG_W = 24
) (
  input  logic [2*SIG_W:0]  prod,
  input  logic [2*SIG_W:0]  sum_hi,
  input  logic [2*SIG_W:0]  sum_lo,
  input  logic              tie_hi,
  input  logic              tie_lo,
  input  logic [SIG_W-1:0]  keep,
  output logic [SIG_W-2:0]  frac,
  output exp_adj_e          adj
);
  localparam int SUM_W  = 2*SIG_W + 1;
  localparam int FRAC_W = SIG_W - 1;

  logic [SUM_W-1:0] chosen;
  logic [SIG_W-1:0] sig;

  always_comb begin
    if (prod[SUM_W-2]) chosen = tie_hi ? prod : sum_hi;
    else               chosen = tie_lo ? prod : sum_lo;

    if (chosen[SUM_W-1]) begin
      adj = ADJ_TWO;
      sig = '0;
    end else if (chosen[SUM_W-2]) begin
      adj = ADJ_ONE;
      sig = SIG_W'(chosen >> SIG_W);
    end else begin
      adj = ADJ_NONE;
      sig = SIG_W'(chosen >> (SIG_W-1));
    end
    frac = FRAC_W'(sig & keep);
  end
endmodule

// File: rtl/sig_round_unit.sv
module sig_round_unit
  import tfr_pkg::*;
#(
  parameter int SIG_W    = tfr_pkg::SIG_W,
  parameter int PREC_W   = tfr_pkg::PREC_W,
  parameter int MIN_PREC = tfr_pkg::MIN_PREC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [2*SIG_W-1:0]   in_prod,
  input  logic [PREC_W-1:0]    in_prec,
  input  logic                 in_flush,
  output logic                 o_valid,
  input  logic                 o_ready,
  output logic [SIG_W-2:0]     o_frac,
  output logic [1:0]           o_adj
);
  localparam int SUM_W  = 2*SIG_W + 1;
  localparam int FRAC_W = SIG_W - 1;

  logic              trunc;
  logic [SUM_W-1:0]  rnd_lo, below_lo, prod_x;
  logic [SIG_W-1:0]  keep;
  logic [SUM_W-1:0]  r_pos [2];
  logic [SUM_W-1:0]  l_pos [2];
  logic [SUM_W-1:0]  below [2];
  logic [SUM_W-1:0]  sum   [2];
  logic              tie   [2];
  logic [FRAC_W-1:0] frac_d, frac_q;
  exp_adj_e          adj_d, adj_q;
  logic              valid_q, take;

  assign prod_x = {1'b0, in_prod};

  tfr_decode #(.SIG_W(SIG_W), .PREC_W(PREC_W), .MIN_PREC(MIN_PREC)) u_dec (
    .prec(in_prec), .trunc(trunc), .rnd_lo(rnd_lo), .below_lo(below_lo), .keep(keep)
  );

  // index 0: leading one at bit 46, index 1: leading one at bit 47
  for (genvar g = 0; g < 2; g++) begin : g_spec
    if (g == 0) begin : g_lo
      assign r_pos[g] = rnd_lo;
      assign below[g] = below_lo;
    end else begin : g_hi
      assign r_pos[g] = rnd_lo << 1;
      assign below[g] = below_lo | rnd_lo;
    end
    assign l_pos[g] = r_pos[g] << 1;
    assign sum[g]   = prod_x + r_pos[g];
    tfr_tie #(.SUM_W(SUM_W)) u_tie (
      .prod(prod_x), .l_pos(l_pos[g]), .r_pos(r_pos[g]), .below(below[g]), .tie(tie[g])
    );
  end

  tfr_pick #(.SIG_W(SIG_W)) u_pick (
    .prod(prod_x), .sum_hi(sum[1]), .sum_lo(sum[0]),
    .tie_hi(tie[1] && !trunc), .tie_lo(tie[0] && !trunc),
    .keep(keep), .frac(frac_d), .adj(adj_d)
  );

  assign in_ready = !valid_q || o_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else if (in_ready) valid_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      frac_q <= in_flush ? '0 : frac_d;
      adj_q  <= in_flush ? ADJ_NONE : adj_d;
    end
  end

  assign o_valid = valid_q;
  assign o_frac  = frac_q;
  assign o_adj   = adj_q;
endmodule

// File: rtl/sig_round_chk.sv
module sig_round_chk #(
  parameter int SIG_W    = 24,
  parameter int PREC_W   = 5,
  parameter int MIN_PREC = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [2*SIG_W-1:0] in_prod,
  input logic [PREC_W-1:0]  in_prec,
  input logic               in_flush,
  input logic               o_valid,
  input logic               o_ready,
  input logic [SIG_W-2:0]   o_frac,
  input logic [1:0]         o_adj
);
  localparam int FRAC_W = SIG_W - 1;

  function automatic logic [FRAC_W-1:0] low_zero(input logic [PREC_W-1:0] p);
    int me;
    me = (int'(p) > SIG_W) ? SIG_W : ((int'(p) < MIN_PREC) ? MIN_PREC : int'(p));
    return FRAC_W'((64'd1 << (SIG_W - me)) - 64'd1);
  endfunction

  logic acc;
  assign acc = in_valid && in_ready;

  // R9
  accept_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> o_valid);

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_frac) && $stable(o_adj)));

  // R7
  prec_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ((o_frac & low_zero($past(in_prec))) == '0));

  // R8
  flush_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_flush) |=> (o_frac == '0 && o_adj == 2'd0));

  // R5
  trunc_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_flush && int'(in_prec) > SIG_W && in_prod[2*SIG_W-1])
      |=> (o_adj == 2'd1 && o_frac == $past(FRAC_W'(in_prod >> SIG_W))));

  // R4
  adj_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> (o_adj != 2'd3));
endmodule

bind sig_round_unit sig_round_chk #(.SIG_W(SIG_W), .PREC_W(PREC_W), .MIN_PREC(MIN_PREC)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_prod(in_prod),
  .in_prec(in_prec), .in_flush(in_flush), .o_valid(o_valid), .o_ready(o_ready),
  .o_frac(o_frac), .o_adj(o_adj)
);

// File: tb/test_sig_round_unit.sv
module test_sig_round_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [47:0] in_prod = '0;
  logic [4:0]  in_prec = 5'd24;
  logic        in_flush = 1'b0;
  logic        o_valid;
  logic        o_ready = 1'b0;
  logic [22:0] o_frac;
  logic [1:0]  o_adj;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  sig_round_unit i_sig_round_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_prod(in_prod), .in_prec(in_prec), .in_flush(in_flush),
    .o_valid(o_valid), .o_ready(o_ready), .o_frac(o_frac), .o_adj(o_adj)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // nearest-even model from the requirements
  function automatic void model(input logic [47:0] p, input logic [4:0] pr, input logic fl,
                                output logic [22:0] f, output logic [1:0] a);
    int me, msb, k, mr;
    logic [63:0] q, rem, half, r;
    bit tr;
    if (fl) begin f = '0; a = '0; return; end
    tr  = pr > 5'd24;
    me  = tr ? 24 : ((pr < 5'd4) ? 4 : int'(pr));
    msb = p[47] ? 47 : 46;
    k   = msb - me + 1;
    q    = 64'(p) >> k;
    rem  = 64'(p) & ((64'd1 << k) - 64'd1);
    half = 64'd1 << (k - 1);
    if (!tr && (rem > half || (rem == half && q[0]))) q = q + 64'd1;
    r  = q << k;
    mr = r[48] ? 48 : (r[47] ? 47 : 46);
    a  = 2'(mr - 46);
    f  = 23'(r >> (mr - 23));
  endfunction

  task automatic run_op(input logic [47:0] p, input logic [4:0] pr, input logic fl,
                        input int hold, input string tag);
    logic [22:0] ef, f0;
    logic [1:0]  ea, a0;
    model(p, pr, fl, ef, ea);
    in_prod = p; in_prec = pr; in_flush = fl; in_valid = 1'b1; o_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    chk(o_valid === 1'b1, "R9 result valid after accept", 64'(o_valid), 64'd1);
    f0 = o_frac; a0 = o_adj;
    if (hold > 0) begin
      chk(in_ready === 1'b0, "R9 stalled input", 64'(in_ready), 64'd0);
      repeat (hold) @(negedge clk);
      chk(o_valid === 1'b1 && o_frac === f0 && o_adj === a0, "R10 held output",
          {39'(0), o_adj, o_frac}, {39'(0), a0, f0});
    end
    chk(o_frac === ef && o_adj === ea, tag, {39'(0), o_adj, o_frac}, {39'(0), ea, ef});
    o_ready = 1'b1;
    @(negedge clk);
    o_ready = 1'b0;
  endtask

  function automatic logic [47:0] rnd48();
    return 48'({$urandom, $urandom});
  endfunction

  function automatic logic [47:0] rnd_prod();
    logic [23:0] x, y;
    x = {1'b1, 23'($urandom)};
    y = {1'b1, 23'($urandom)};
    return 48'(x) * 48'(y);
  endfunction

  initial begin : watchdog
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<190000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    chk(o_valid === 1'b0 && in_ready === 1'b1, "R11 reset state",
        {62'(0), o_valid, in_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(o_valid === 1'b0 && in_ready === 1'b1, "R11 after release",
        {62'(0), o_valid, in_ready}, 64'd1);

    for (int pr = 0; pr < 32; pr++) begin
      int me;
      logic [47:0] p;
      me = (pr > 24) ? 24 : ((pr < 4) ? 4 : pr);
      for (int n = 0; n < 90; n++) begin
        p = rnd_prod();
        run_op(p, 5'(pr), 1'b0, n % 3, p[47] ? "R2 random hi" : "R1 random lo");
      end
      for (int n = 0; n < 4; n++) begin
        // exact half at bit-47 position, random kept LSB
        p = (rnd48() | (48'd1 << 47)) & ~((48'd1 << (48 - me)) - 48'd1);
        p = p | (48'd1 << (47 - me));
        run_op(p, 5'(pr), 1'b0, 0, (pr > 24) ? "R5 truncation hi" : "R3 tie hi");
        // exact half at bit-46 position
        p = ((rnd48() & ((48'd1 << 47) - 48'd1)) | (48'd1 << 46)) & ~((48'd1 << (47 - me)) - 48'd1);
        p = p | (48'd1 << (46 - me));
        run_op(p, 5'(pr), 1'b0, 1, (pr > 24) ? "R5 truncation lo" : "R3 tie lo");
      end
      run_op(48'hFFFF_FFFF_FFFF, 5'(pr), 1'b0, 0, "R4 carry to bit 48");
      run_op(48'h7FFF_FFFF_FFFF, 5'(pr), 1'b0, 0, "R4 carry to bit 47");
      run_op((48'd1 << 47) - (48'd1 << (47 - me)), 5'(pr), 1'b0, 0, "R1 all ones lo no carry");
      run_op(rnd_prod(), 5'(pr), 1'b1, 1, "R8 flush");
      if (pr < 4) run_op(48'h5555_5555_5555, 5'(pr), 1'b0, 0, "R6 clamp to four");
      run_op(rnd_prod(), 5'(pr), 1'b0, 0, "R7 low fraction bits");
    end

    // R6: codes below four match code four exactly
    for (int pr = 0; pr < 4; pr++) begin
      logic [22:0] f4; logic [1:0] a4; logic [47:0] p;
      p = rnd_prod();
      model(p, 5'd4, 1'b0, f4, a4);
      in_prod = p; in_prec = 5'(pr); in_flush = 1'b0; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(o_frac === f4 && o_adj === a4, "R6 same as four", {39'(0), o_adj, o_frac}, {39'(0), a4, f4});
      o_ready = 1'b1; @(negedge clk); o_ready = 1'b0;
    end

    // R9: back-to-back streaming with consumer always ready
    begin
      logic [22:0] ef; logic [1:0] ea;
      logic [47:0] prev_p; logic [4:0] prev_m;
      o_ready = 1'b1;
      prev_p = '0; prev_m = '0;
      for (int n = 0; n < 41; n++) begin
        if (n < 40) begin
          in_prod = rnd_prod(); in_prec = 5'(4 + (n % 21)); in_flush = 1'b0; in_valid = 1'b1;
        end else in_valid = 1'b0;
        if (n > 0) begin
          model(prev_p, prev_m, 1'b0, ef, ea);
          chk(o_valid === 1'b1 && o_frac === ef && o_adj === ea, "R9 streaming",
              {38'(0), o_valid, o_adj, o_frac}, {38'(0), 1'b1, ea, ef});
        end
        prev_p = in_prod; prev_m = in_prec;
        @(negedge clk);
      end
      chk(o_valid === 1'b0, "R9 drained", 64'(o_valid), 64'd0);
      o_ready = 1'b0;
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule